// File: doc/BRIEF.md
# LPC Firmware Memory Bus Target

This block sits on the target side of a 4-bit multiplexed LPC bus and answers firmware memory read and write cycles. It samples the frame strobe (`lframe_n`) and the shared nibble bus on every rising clock edge. From these it collects the cycle type, the device select nibble, a 28-bit byte address, the size nibble and, on writes, one data byte. When a cycle is addressed to this device, it asks an internal memory port for one byte. While waiting, it drives sync nibbles. It then returns the read data, or confirms the write, and hands the bus back to the host.

The memory side is a simple request/ready pair. A request stays up from the first turnaround clock until the port accepts it with `mem_ready`. If the port accepts within the two turnaround clocks, the target answers with no wait states. A host that pulls `lframe_n` low at any point ends the current cycle at once. That clock is then taken as the start of a new frame.

Top module: `fwmem_lpc_target`

## Requirements
- R1: While `rst` is high, and in the cycle after it falls, `lad_oe` and `mem_req` are 0.
- R2: The cycle code is the `lad_in` value sampled at the last rising edge where `lframe_n` is low. A low phase may last several clocks. Code 4'b1101 starts a read (`mem_we`=0) and 4'b1110 starts a write (`mem_we`=1). Any other code is ignored: no request and no bus drive.
- R3: The nibble on the first clock after the frame strobe rises is compared with `id_strap`. On a mismatch the target issues no request and never drives LAD for that cycle.
- R4: Seven address nibbles follow, most significant first. `mem_addr` holds the assembled 28-bit address while `mem_req` is high.
- R5: The nibble after the address is the size. Any value other than 4'b0000 makes the target drop the cycle with no request and no bus drive.
- R6: On a read, the target keeps LAD released for the two clocks after the size nibble. It then drives sync, then data bits [3:0], then bits [7:4], then 4'b1111 for one clock, and then releases LAD.
- R7: On a write, the two clocks after the size nibble carry data bits [3:0] and then [7:4], and these appear on `mem_wdata`. LAD stays released for the next two clocks. The target then drives sync, then 4'b1111 for one clock, and then releases LAD.
- R8: In each sync clock the target drives 4'b0101 until the request has been accepted at a clock edge, and then drives 4'b0000 for exactly one clock. A port that is ready from the first request clock gives 4'b0000 in the first sync clock. A port that first becomes ready in request clock d (counting from 0) gives max(d-1,0) clocks of 4'b0101.
- R9: `mem_req` rises in the first turnaround clock and stays high until the first edge where `mem_ready` is also high. It is high for exactly d+1 clocks.
- R10: If `lframe_n` is sampled low in the middle of a cycle, LAD is released and `mem_req` is withdrawn in the next clock. The same clock is taken as a new start, so a following valid frame is served normally.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock; all sampling on the rising edge |
| rst | input | 1 | Synchronous active-high reset |
| lframe_n | input | 1 | Frame strobe from the host, active low |
| lad_in | input | 4 | Nibble bus as seen at the pins |
| lad_out | output | 4 | Nibble driven by the target when `lad_oe` is high |
| lad_oe | output | 1 | Output enable for `lad_out` |
| id_strap | input | 4 | Device select strap value |
| mem_req | output | 1 | Byte access request to the memory port |
| mem_we | output | 1 | 1 for write, 0 for read; valid with `mem_req` |
| mem_addr | output | 28 | Byte address; valid with `mem_req` |
| mem_wdata | output | 8 | Write byte; valid with `mem_req` on writes |
| mem_rdata | input | 8 | Read byte from the port, taken when accepted |
| mem_ready | input | 1 | Port accepts the request at this edge |

## Verification
The hardest situation to reach is a frame abort that lands while a request is still outstanding and the target is driving wait syncs. Reaching it needs a full, correctly addressed cycle with a slow memory port, and then a strobe at exactly the right clock. The bench builds this from its ready model: it holds `mem_ready` low for a long delay, lets a few 4'b0101 syncs appear, and then pulls `lframe_n` low with an invalid code. It then checks that the bus and the request both drop in the next clock and stay quiet. A second directed case aborts partway through the address phase and restarts straight into a valid write.

// File: rtl/fwmem_pkg.sv
package fwmem_pkg;

    localparam logic [3:0] START_READ  = 4'b1101;
    localparam logic [3:0] START_WRITE = 4'b1110;
    localparam logic [3:0] SYNC_READY  = 4'b0000;
    localparam logic [3:0] SYNC_SHORT  = 4'b0101;
    localparam logic [3:0] NIB_RELEASE = 4'b1111;
    localparam logic [3:0] SIZE_BYTE   = 4'b0000;

    typedef enum logic [3:0] {
        ST_IDLE,
        ST_FRAME,
        ST_ADDR,
        ST_SIZE,
        ST_WLO,
        ST_WHI,
        ST_TAR0,
        ST_TAR1,
        ST_SYNC,
        ST_RLO,
        ST_RHI,
        ST_HND0,
        ST_HND1
    } fw_state_e;

    typedef enum logic [1:0] {
        KIND_NONE,
        KIND_READ,
        KIND_WRITE
    } fw_kind_e;

    typedef struct packed {
        logic       oe;
        logic [3:0] nib;
    } lad_drive_t;

    function automatic fw_kind_e start_kind(input logic [3:0] code);
        fw_kind_e k;
        if (code == START_READ) begin
            k = KIND_READ;
        end else if (code == START_WRITE) begin
            k = KIND_WRITE;
        end else begin
            k = KIND_NONE;
        end
        return k;
    endfunction

endpackage

// File: rtl/fwmem_seq.sv
module fwmem_seq
    import fwmem_pkg::*;
#(
    parameter int ADDR_NIBS = 7,
    localparam int ADDR_W = 4 * ADDR_NIBS,
    localparam int CNT_W  = (ADDR_NIBS > 1) ? $clog2(ADDR_NIBS) : 1
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              lframe_n,
    input  logic [3:0]        lad_in,
    input  logic [3:0]        id_strap,
    input  logic              done,
    output fw_state_e         state,
    output logic              is_write,
    output logic              issue,
    output logic [ADDR_W-1:0] addr,
    output logic [7:0]        wdata
);

    localparam logic [CNT_W-1:0] LAST_NIB = CNT_W'(ADDR_NIBS - 1);

    fw_state_e         state_q;
    fw_kind_e          kind_q;
    logic [3:0]        start_q;
    logic [CNT_W-1:0]  cnt_q;
    logic [ADDR_W-1:0] addr_q;
    logic [7:0]        wdata_q;
    fw_kind_e          seen_kind;

    assign seen_kind = start_kind(start_q);

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= ST_IDLE;
            kind_q  <= KIND_NONE;
            start_q <= '0;
            cnt_q   <= '0;
            addr_q  <= '0;
            wdata_q <= '0;
        end else if (!lframe_n) begin
            state_q <= ST_FRAME;
            start_q <= lad_in;
        end else begin
            unique case (state_q)
                ST_IDLE: state_q <= ST_IDLE;
                ST_FRAME: begin
                    if (seen_kind != KIND_NONE && lad_in == id_strap) begin
                        kind_q  <= seen_kind;
                        cnt_q   <= '0;
                        state_q <= ST_ADDR;
                    end else begin
                        state_q <= ST_IDLE;
                    end
                end
                ST_ADDR: begin
                    addr_q <= {addr_q[ADDR_W-5:0], lad_in};
                    if (cnt_q == LAST_NIB) begin
                        state_q <= ST_SIZE;
                    end else begin
                        cnt_q <= cnt_q + 1'b1;
                    end
                end
                ST_SIZE: begin
                    if (lad_in != SIZE_BYTE) begin
                        state_q <= ST_IDLE;
                    end else if (kind_q == KIND_WRITE) begin
                        state_q <= ST_WLO;
                    end else begin
                        state_q <= ST_TAR0;
                    end
                end
                ST_WLO: begin
                    wdata_q[3:0] <= lad_in;
                    state_q      <= ST_WHI;
                end
                ST_WHI: begin
                    wdata_q[7:4] <= lad_in;
                    state_q      <= ST_TAR0;
                end
                ST_TAR0: state_q <= ST_TAR1;
                ST_TAR1: state_q <= ST_SYNC;
                ST_SYNC: begin
                    if (done) begin
                        state_q <= (kind_q == KIND_READ) ? ST_RLO : ST_HND0;
                    end
                end
                ST_RLO:  state_q <= ST_RHI;
                ST_RHI:  state_q <= ST_HND0;
                ST_HND0: state_q <= ST_HND1;
                ST_HND1: state_q <= ST_IDLE;
                default: state_q <= ST_IDLE;
            endcase
        end
    end

    assign issue = lframe_n &&
                   ((state_q == ST_SIZE && lad_in == SIZE_BYTE && kind_q == KIND_READ) ||
                    (state_q == ST_WHI));

    assign state    = state_q;
    assign is_write = (kind_q == KIND_WRITE);
    assign addr     = addr_q;
    assign wdata    = wdata_q;

    // R10
    abort_restart_chk: assert property (@(posedge clk) disable iff (rst)
        !lframe_n |=> state_q == ST_FRAME);

    // R4
    addr_len_chk: assert property (@(posedge clk) disable iff (rst)
        (lframe_n && state_q == ST_ADDR && cnt_q == LAST_NIB) |=> state_q == ST_SIZE);

endmodule

// File: rtl/fwmem_port.sv
module fwmem_port (
    input  logic       clk,
    input  logic       rst,
    input  logic       issue,
    input  logic       abort,
    input  logic       mem_ready,
    input  logic [7:0] mem_rdata,
    output logic       mem_req,
    output logic       done,
    output logic [7:0] rdata
);

    logic       req_q;
    logic       done_q;
    logic [7:0] rdata_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            req_q   <= 1'b0;
            done_q  <= 1'b0;
            rdata_q <= '0;
        end else if (abort) begin
            req_q  <= 1'b0;
            done_q <= 1'b0;
        end else if (issue) begin
            req_q  <= 1'b1;
            done_q <= 1'b0;
        end else if (req_q && mem_ready) begin
            req_q   <= 1'b0;
            done_q  <= 1'b1;
            rdata_q <= mem_rdata;
        end
    end

    assign mem_req = req_q;
    assign done    = done_q;
    assign rdata   = rdata_q;

    // R9
    req_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (mem_req && !mem_ready && !abort) |=> mem_req);

    // R8
    req_done_excl_chk: assert property (@(posedge clk) disable iff (rst)
        mem_req |-> !done);

endmodule

// File: rtl/fwmem_drive.sv
module fwmem_drive
    import fwmem_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  fw_state_e  state,
    input  logic       done,
    input  logic [7:0] rdata,
    output lad_drive_t drv
);

    always_comb begin
        drv = '{oe: 1'b0, nib: NIB_RELEASE};
        unique case (state)
            ST_SYNC: drv = '{oe: 1'b1, nib: (done ? SYNC_READY : SYNC_SHORT)};
            ST_RLO:  drv = '{oe: 1'b1, nib: rdata[3:0]};
            ST_RHI:  drv = '{oe: 1'b1, nib: rdata[7:4]};
            ST_HND0: drv = '{oe: 1'b1, nib: NIB_RELEASE};
            default: drv = '{oe: 1'b0, nib: NIB_RELEASE};
        endcase
    end

    // R6
    first_drive_sync_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(drv.oe) |-> (drv.nib == SYNC_SHORT || drv.nib == SYNC_READY));

endmodule

// File: rtl/fwmem_lpc_target.sv
module fwmem_lpc_target
    import fwmem_pkg::*;
#(
    parameter int ADDR_NIBS = 7,
    localparam int ADDR_W = 4 * ADDR_NIBS
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              lframe_n,
    input  logic [3:0]        lad_in,
    output logic [3:0]        lad_out,
    output logic              lad_oe,
    input  logic [3:0]        id_strap,
    output logic              mem_req,
    output logic              mem_we,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [7:0]        mem_wdata,
    input  logic [7:0]        mem_rdata,
    input  logic              mem_ready
);

    fw_state_e  state;
    logic       issue;
    logic       done;
    logic [7:0] rdata;
    lad_drive_t drv;

    fwmem_seq #(.ADDR_NIBS(ADDR_NIBS)) i_seq (
        .clk      (clk),
        .rst      (rst),
        .lframe_n (lframe_n),
        .lad_in   (lad_in),
        .id_strap (id_strap),
        .done     (done),
        .state    (state),
        .is_write (mem_we),
        .issue    (issue),
        .addr     (mem_addr),
        .wdata    (mem_wdata)
    );

    fwmem_port i_port (
        .clk       (clk),
        .rst       (rst),
        .issue     (issue),
        .abort     (!lframe_n),
        .mem_ready (mem_ready),
        .mem_rdata (mem_rdata),
        .mem_req   (mem_req),
        .done      (done),
        .rdata     (rdata)
    );

    fwmem_drive i_drive (
        .clk   (clk),
        .rst   (rst),
        .state (state),
        .done  (done),
        .rdata (rdata),
        .drv   (drv)
    );

    assign lad_oe  = drv.oe;
    assign lad_out = drv.nib;

    // R10
    abort_release_chk: assert property (@(posedge clk) disable iff (rst)
        !lframe_n |=> (!lad_oe && !mem_req));

    // R1
    reset_quiet_chk: assert property (@(posedge clk)
        rst |=> (!lad_oe && !mem_req));

endmodule

// File: tb/test_fwmem_lpc_target.sv
module test_fwmem_lpc_target;

    typedef struct packed {
        logic        wr;
        logic [3:0]  start;
        logic [3:0]  idsel;
        logic [27:0] addr;
        logic [3:0]  msize;
        logic [7:0]  wdata;
        logic [7:0]  rdata;
        logic [3:0]  delay;
        logic        resp;
    } vec_t;

    localparam int NVEC = 9;
    localparam vec_t VECS [NVEC] = '{
        '{1'b0, 4'hD, 4'h3, 28'hFFBC002, 4'h0, 8'h00, 8'hA5, 4'd0, 1'b1},
        '{1'b1, 4'hE, 4'h3, 28'h0123456, 4'h0, 8'h3C, 8'h00, 4'd0, 1'b1},
        '{1'b0, 4'hD, 4'h3, 28'h7654321, 4'h0, 8'h00, 8'h96, 4'd3, 1'b1},
        '{1'b1, 4'hE, 4'h3, 28'hABCDEF1, 4'h0, 8'hE7, 8'h00, 4'd5, 1'b1},
        '{1'b0, 4'hD, 4'h5, 28'h1111111, 4'h0, 8'h00, 8'h11, 4'd0, 1'b0},
        '{1'b1, 4'h2, 4'h3, 28'h2222222, 4'h0, 8'h22, 8'h00, 4'd0, 1'b0},
        '{1'b0, 4'hD, 4'h3, 28'h3333333, 4'h1, 8'h00, 8'h33, 4'd0, 1'b0},
        '{1'b1, 4'hE, 4'h3, 28'h4444444, 4'h7, 8'h44, 8'h00, 4'd0, 1'b0},
        '{1'b0, 4'hD, 4'h3, 28'hFFFFFFF, 4'h0, 8'h00, 8'h0F, 4'd1, 1'b1}
    };

    logic        clk = 1'b0;
    logic        rst;
    logic        lframe_n;
    logic [3:0]  lad_in;
    logic [3:0]  lad_out;
    logic        lad_oe;
    logic [3:0]  id_strap;
    logic        mem_req;
    logic        mem_we;
    logic [27:0] mem_addr;
    logic [7:0]  mem_wdata;
    logic [7:0]  mem_rdata;
    logic        mem_ready;

    always #5 clk = ~clk;

    fwmem_lpc_target i_fwmem_lpc_target (
        .clk       (clk),
        .rst       (rst),
        .lframe_n  (lframe_n),
        .lad_in    (lad_in),
        .lad_out   (lad_out),
        .lad_oe    (lad_oe),
        .id_strap  (id_strap),
        .mem_req   (mem_req),
        .mem_we    (mem_we),
        .mem_addr  (mem_addr),
        .mem_wdata (mem_wdata),
        .mem_rdata (mem_rdata),
        .mem_ready (mem_ready)
    );

    int          n_checks = 0;
    int          n_fails  = 0;
    bit          finished = 0;
    logic        obs_oe;
    logic [3:0]  obs_nib;
    bit          saw_req, saw_oe;
    int          req_cycles, req_cnt, cur_delay;
    logic [27:0] rq_addr;
    logic        rq_we;
    logic [7:0]  rq_wd;

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fails++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic step(input logic lf, input logic [3:0] d);
        @(negedge clk);
        obs_oe  = lad_oe;
        obs_nib = lad_out;
        if (lad_oe) saw_oe = 1;
        if (mem_req) begin
            saw_req = 1;
            req_cycles++;
            rq_addr = mem_addr;
            rq_we   = mem_we;
            rq_wd   = mem_wdata;
            mem_ready = (req_cnt == cur_delay);
            req_cnt++;
        end else begin
            mem_ready = 1'b0;
            req_cnt   = 0;
        end
        lframe_n = lf;
        lad_in   = d;
    endtask

    task automatic send_header(input vec_t v);
        step(1'b0, v.start);
        step(1'b1, v.idsel);
        for (int i = 6; i >= 0; i--) step(1'b1, v.addr[4*i +: 4]);
        step(1'b1, v.msize);
        if (v.wr) begin
            step(1'b1, v.wdata[3:0]);
            step(1'b1, v.wdata[7:4]);
        end
    endtask

    task automatic run_vec(input vec_t v);
        int waits;
        saw_req = 0; saw_oe = 0; req_cycles = 0;
        cur_delay = int'(v.delay);
        mem_rdata = v.rdata;
        send_header(v);
        if (!v.resp) begin
            repeat (8) step(1'b1, 4'hF);
            check("R2/R3/R5 ignored cycle drives LAD", 32'(saw_oe), 32'd0);
            check("R2/R3/R5 ignored cycle requests", 32'(saw_req), 32'd0);
            return;
        end
        step(1'b1, 4'hF);
        check("R6 R7 first turnaround released", 32'(obs_oe), 32'd0);
        step(1'b1, 4'hF);
        check("R6 R7 second turnaround released", 32'(obs_oe), 32'd0);
        waits = 0;
        for (int k = 0; k < 40; k++) begin
            step(1'b1, 4'hF);
            if (obs_oe && obs_nib == 4'h5) waits++;
            else break;
        end
        check("R8 ready sync", {27'd0, obs_oe, obs_nib}, {27'd0, 1'b1, 4'h0});
        check("R8 short wait count", 32'(waits), (v.delay > 1) ? 32'(v.delay - 1) : 32'd0);
        check("R9 request length", 32'(req_cycles), 32'(v.delay) + 32'd1);
        check("R4 address", {4'd0, rq_addr}, {4'd0, v.addr});
        check("R2 direction", 32'(rq_we), 32'(v.wr));
        if (v.wr) begin
            check("R7 write data", 32'(rq_wd), 32'(v.wdata));
        end else begin
            step(1'b1, 4'hF);
            check("R6 low data nibble", {27'd0, obs_oe, obs_nib}, {27'd0, 1'b1, v.rdata[3:0]});
            step(1'b1, 4'hF);
            check("R6 high data nibble", {27'd0, obs_oe, obs_nib}, {27'd0, 1'b1, v.rdata[7:4]});
        end
        step(1'b1, 4'hF);
        check("R6 R7 handback 1111", {27'd0, obs_oe, obs_nib}, {27'd0, 1'b1, 4'hF});
        step(1'b1, 4'hF);
        check("R6 R7 release", 32'(obs_oe), 32'd0);
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!finished) begin
            n_fails++;
            $display("FAIL watchdog expired");
            $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fails);
            $finish;
        end
    end

    initial begin
        vec_t v;
        rst = 1'b1; lframe_n = 1'b1; lad_in = 4'hF; id_strap = 4'h3;
        mem_rdata = '0; mem_ready = 1'b0; cur_delay = 0; req_cnt = 0;
        repeat (3) @(negedge clk);
        // R1 reset state
        check("R1 lad_oe in reset", 32'(lad_oe), 32'd0);
        check("R1 mem_req in reset", 32'(mem_req), 32'd0);
        rst = 1'b0;
        step(1'b1, 4'hF);
        check("R1 lad_oe after reset", 32'(lad_oe), 32'd0);

        for (int i = 0; i < NVEC; i++) begin
            run_vec(VECS[i]);
            step(1'b1, 4'hF);
        end

        // R2 start code held low over two clocks, last value counts
        step(1'b0, 4'h0);
        run_vec(VECS[0]);
        step(1'b1, 4'hF);

        // R10 abort in the address phase, restart as a write
        step(1'b0, 4'hD);
        step(1'b1, 4'h3);
        step(1'b1, 4'h1);
        step(1'b1, 4'h2);
        run_vec(VECS[1]);
        step(1'b1, 4'hF);

        // R10 abort while waiting on a slow port
        v = VECS[2];
        v.delay = 4'd12;
        saw_req = 0; saw_oe = 0; req_cycles = 0;
        cur_delay = int'(v.delay);
        mem_rdata = v.rdata;
        send_header(v);
        repeat (5) step(1'b1, 4'hF);
        check("R10 waiting before abort", {27'd0, obs_oe, obs_nib}, {27'd0, 1'b1, 4'h5});
        check("R10 request pending before abort", 32'(mem_req), 32'd1);
        step(1'b0, 4'hF);
        step(1'b1, 4'hF);
        check("R10 LAD released after abort", 32'(obs_oe), 32'd0);
        check("R10 request withdrawn after abort", 32'(mem_req), 32'd0);
        saw_oe = 0; saw_req = 0;
        repeat (6) step(1'b1, 4'hF);
        check("R10 quiet after abort", 32'(saw_oe), 32'd0);
        check("R10 no request after abort", 32'(saw_req), 32'd0);

        finished = 1;
        $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fails);
        $finish;
    end

endmodule